// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Mask Aliases and Fast/Normal Steering

This block gathers 96 level-sensitive interrupt lines and hands one winner at a time to a processor on each of two request outputs. One output is the normal request and the other is the fast request. The lines are handled in three groups of 32. Line n lives in group n/32 at bit n%32. Each group holds a mask, a set of software-raised request bits, and read-only views of the raw lines and of what is pending for each output. Each line also has its own configuration word that picks its output and sets a 6-bit priority.

Each output has its own arbiter. It picks the pending line with the numerically smallest priority and breaks ties in favour of the lowest line number. The winner is then frozen: the reported number, its priority and the request output all stay put until software writes an acknowledge for that output. Only then does a new selection take place. A global threshold can hold back lines whose priority is not urgent enough. A configuration bit restores every register to its reset state.

All access goes through a single-cycle word-addressed bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `vec_intc`

Register map (word addresses):
- 0x00 configuration: bit 1 is soft reset.
- 0x01 status: bit 0 is reset done.
- 0x02 normal winner number.
- 0x03 fast winner number.
- 0x04 acknowledge: bit 0 for normal, bit 1 for fast.
- 0x05 normal winner priority.
- 0x06 fast winner priority.
- 0x07 threshold.
- Group registers start at 0x10 + 8*group. By offset: 0 raw, 1 mask, 2 mask-set, 3 mask-clear, 4 software-set (reads back the software bits), 5 software-clear, 6 pending-normal, 7 pending-fast.
- Line configuration words sit at 0x80 + n.

## Requirements
- R1: After reset both request outputs are low, every mask register reads 0xFFFFFFFF, the threshold reads 0xFF, every line configuration word reads 0 and status bit 0 reads 1.
- R2: A mask bit of 1 blocks its line. Writing 1s to the mask-set alias (group offset 2) sets those mask bits. Writing 1s to the mask-clear alias (offset 3) clears them. Bits written as 0 leave the mask unchanged. The mask reads at offset 1.
- R3: A line is pending-normal when (raw OR software bit) AND NOT mask AND its steering bit is 0. It is pending-fast under the same rule with the steering bit at 1. The two views read at offsets 6 and 7.
- R4: Writing 1s at group offset 4 raises software request bits. Writing 1s at offset 5 clears them. Offset 4 reads the bits back. A software bit requests its line exactly as the raw input does.
- R5: The line configuration word at 0x80+n has bit 0 as the steering bit (1 = fast output) and bits 7:2 as the priority. Bit 1 and bits above 7 read as 0.
- R6: Among eligible lines, the one with the smallest priority value wins. On equal priority the lowest line number wins. The winner's number reads in the low 7 bits of 0x02 (normal) or 0x03 (fast). Its request output rises in the cycle after the line becomes pending.
- R7: While a winner is held, its number and request output stay unchanged even if the line drops or a more urgent line arrives.
- R8: Writing 1 to bit 0 (normal) or bit 1 (fast) at 0x04 drops that output in the next cycle. A fresh selection follows one cycle later.
- R9: With the threshold at 0xFF all priorities are eligible. With any other value, only lines whose priority is numerically below the threshold are delivered.
- R10: Addresses 0x05 and 0x06 read the 6-bit priority of the held normal and fast winners.
- R11: Writing 1 to bit 1 at 0x00 returns every register to its R1 value at the next edge. Status bit 0 reads 0 for the one cycle after the write and 1 afterwards.
- R12: The raw register (group offset 0) shows the input lines whether or not they are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| src_i | input | 96 | Level interrupt lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted mask or software bit shows up in the group's pending view in the same cycle, and at the request output one cycle later. A wrong comparison in the arbiter appears only at the next selection, so every table case forces a new selection and reads the winner number and priority at once. A hold register that fails to freeze is caught by bringing in a more urgent line and dropping the held one while a winner is outstanding, then reading the winner number. A broken acknowledge or soft reset path shows at the outputs and status bit within one or two cycles of the write.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  // register offsets inside one line group
  typedef enum logic [2:0] {
    GRP_RAW  = 3'd0,
    GRP_MASK = 3'd1,
    GRP_MSET = 3'd2,
    GRP_MCLR = 3'd3,
    GRP_SSET = 3'd4,
    GRP_SCLR = 3'd5,
    GRP_PNRM = 3'd6,
    GRP_PFST = 3'd7
  } grp_reg_e;

  localparam int REG_CFG    = 0;
  localparam int REG_STAT   = 1;
  localparam int REG_NWIN   = 2;
  localparam int REG_FWIN   = 3;
  localparam int REG_ACK    = 4;
  localparam int REG_NPRI   = 5;
  localparam int REG_FPRI   = 6;
  localparam int REG_THR    = 7;
  localparam int GROUP_BASE = 16;
  localparam int LINE_BASE  = 128;

  localparam int CH_NRM = 0;
  localparam int CH_FST = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/vec_intc_bank.sv
module vec_intc_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic [BANK_W-1:0] src_i,
  input  logic [BANK_W-1:0] steer_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              we_mask_i,
  input  logic              we_mset_i,
  input  logic              we_mclr_i,
  input  logic              we_sset_i,
  input  logic              we_sclr_i,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] swi_o,
  output logic [BANK_W-1:0] pnrm_o,
  output logic [BANK_W-1:0] pfst_o
);
  logic [BANK_W-1:0] mask_q, mask_d;
  logic [BANK_W-1:0] swi_q, swi_d;
  logic              mask_en, swi_en;
  logic [BANK_W-1:0] req;

  assign mask_en = we_mask_i | we_mset_i | we_mclr_i;
  assign swi_en  = we_sset_i | we_sclr_i;

  always_comb begin
    mask_d = mask_q;
    if (we_mask_i) mask_d = wdata_i;
    if (we_mset_i) mask_d = mask_d | wdata_i;
    if (we_mclr_i) mask_d = mask_d & ~wdata_i;
    swi_d = swi_q;
    if (we_sset_i) swi_d = swi_d | wdata_i;
    if (we_sclr_i) swi_d = swi_d & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (srst_i) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (swi_en)  swi_q  <= swi_d;
    end
  end

  assign req    = (src_i | swi_q) & ~mask_q;
  assign raw_o  = src_i;
  assign mask_o = mask_q;
  assign swi_o  = swi_q;
  assign pnrm_o = req & ~steer_i;
  assign pfst_o = req & steer_i;

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mset_i && !srst_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mclr_i && !srst_i) |=> ((mask_q & $past(wdata_i)) == '0));
  // R4
  swi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sclr_i && !srst_i) |=> ((swi_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             elig_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // strict less-than keeps the lowest line number on equal priority
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!found_o || (prio_i[i] < prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

  always_comb begin
    if (found_o) begin
      // R6
      win_elig_chk: assert (elig_i[idx_o]);
    end
  end
endmodule

// File: rtl/vec_intc_hold.sv
module vec_intc_hold #(
  parameter int IDX_W  = 7,
  parameter int PRIO_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              ack_i,
  input  logic              cand_found_i,
  input  logic [IDX_W-1:0]  cand_idx_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  output logic              active_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic              active_q, active_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              upd_en;

  assign upd_en = ack_i | (~active_q & cand_found_i);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    prio_d   = prio_q;
    if (ack_i) begin
      active_d = 1'b0;
    end else if (!active_q && cand_found_i) begin
      active_d = 1'b1;
      idx_d    = cand_idx_i;
      prio_d   = cand_prio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      prio_q   <= '0;
    end else if (srst_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      prio_q   <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
      prio_q   <= prio_d;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign prio_o   = prio_q;

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !active_q);
  // R7
  hold_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !ack_i && !srst_i) |=> (active_q && $stable(idx_q) && $stable(prio_q)));
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NUM_SRC = 96,
  parameter int BANK_W  = 32,
  parameter int PRIO_W  = 6,
  parameter int THR_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  import vec_intc_pkg::*;

  localparam int NUM_BANK = NUM_SRC / BANK_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int GRP0     = GROUP_BASE / 8;
  localparam logic [ADDR_W-1:0] LINE_LO = ADDR_W'(LINE_BASE);
  localparam logic [ADDR_W-1:0] LINE_HI = ADDR_W'(LINE_BASE + NUM_SRC);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // address decode
  logic [ADDR_W-4:0] grp_sel;
  grp_reg_e          grp_kind;
  logic              line_hit;
  logic [IDX_W-1:0]  line_n;
  logic              ctrl_hit, thr_hit, cfg_hit;

  assign grp_sel  = bus_addr_i[ADDR_W-1:3];
  assign grp_kind = grp_reg_e'(bus_addr_i[2:0]);
  assign line_hit = (bus_addr_i >= LINE_LO) && (bus_addr_i < LINE_HI);
  assign line_n   = IDX_W'(bus_addr_i - LINE_LO);
  assign ctrl_hit = (bus_addr_i == ADDR_W'(REG_ACK));
  assign thr_hit  = (bus_addr_i == ADDR_W'(REG_THR));
  assign cfg_hit  = (bus_addr_i == ADDR_W'(REG_CFG));

  // soft reset request, applied at the following edge
  logic srst_q, srst_d;
  assign srst_d = bus_wr_i & cfg_hit & bus_wdata_i[1];
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) srst_q <= 1'b0;
    else           srst_q <= srst_d;
  end

  // acknowledge strobes per output
  logic [NUM_CH-1:0] ack;
  assign ack[CH_NRM] = bus_wr_i & ctrl_hit & bus_wdata_i[0];
  assign ack[CH_FST] = bus_wr_i & ctrl_hit & bus_wdata_i[1];

  // threshold register
  logic [THR_W-1:0] thr_q, thr_d;
  logic             thr_en;
  assign thr_en = bus_wr_i & thr_hit;
  assign thr_d  = bus_wdata_i[THR_W-1:0];
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)   thr_q <= '1;
    else if (srst_q) thr_q <= '1;
    else if (thr_en) thr_q <= thr_d;
  end

  // per-line configuration words
  logic [NUM_SRC-1:0]             steer_q, steer_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic                           line_en;
  assign line_en = bus_wr_i & line_hit;

  always_comb begin
    steer_d = steer_q;
    prio_d  = prio_q;
    steer_d[line_n] = bus_wdata_i[0];
    prio_d[line_n]  = bus_wdata_i[PRIO_W+1:2];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      steer_q <= '0;
      prio_q  <= '0;
    end else if (srst_q) begin
      steer_q <= '0;
      prio_q  <= '0;
    end else if (line_en) begin
      steer_q <= steer_d;
      prio_q  <= prio_d;
    end
  end

  // line groups
  logic [NUM_BANK-1:0][BANK_W-1:0] g_raw, g_mask, g_swi, g_pnrm, g_pfst;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr_i && (grp_sel == (ADDR_W-3)'(GRP0 + b));
    vec_intc_bank #(.BANK_W(BANK_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync),
      .srst_i    (srst_q),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .steer_i   (steer_q[b*BANK_W +: BANK_W]),
      .wdata_i   (bus_wdata_i[BANK_W-1:0]),
      .we_mask_i (hit && (grp_kind == GRP_MASK)),
      .we_mset_i (hit && (grp_kind == GRP_MSET)),
      .we_mclr_i (hit && (grp_kind == GRP_MCLR)),
      .we_sset_i (hit && (grp_kind == GRP_SSET)),
      .we_sclr_i (hit && (grp_kind == GRP_SCLR)),
      .raw_o     (g_raw[b]),
      .mask_o    (g_mask[b]),
      .swi_o     (g_swi[b]),
      .pnrm_o    (g_pnrm[b]),
      .pfst_o    (g_pfst[b])
    );
  end

  // threshold gating
  logic                           thr_off;
  logic [NUM_SRC-1:0]             prio_ok;
  logic [NUM_CH-1:0][NUM_SRC-1:0] ch_elig;
  assign thr_off = &thr_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_thr
    assign prio_ok[i] = thr_off || (THR_W'(prio_q[i]) < thr_q);
  end
  assign ch_elig[CH_NRM] = g_pnrm & prio_ok;
  assign ch_elig[CH_FST] = g_pfst & prio_ok;

  // one arbiter and one hold stage per output
  logic [NUM_CH-1:0]             ch_found, ch_act;
  logic [NUM_CH-1:0][IDX_W-1:0]  ch_cidx, ch_idx;
  logic [NUM_CH-1:0][PRIO_W-1:0] ch_cprio, ch_prio;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vec_intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .elig_i  (ch_elig[c]),
      .prio_i  (prio_q),
      .found_o (ch_found[c]),
      .idx_o   (ch_cidx[c]),
      .prio_o  (ch_cprio[c])
    );
    vec_intc_hold #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_hold (
      .clk          (clk),
      .rst_n        (rst_sync),
      .srst_i       (srst_q),
      .ack_i        (ack[c]),
      .cand_found_i (ch_found[c]),
      .cand_idx_i   (ch_cidx[c]),
      .cand_prio_i  (ch_cprio[c]),
      .active_o     (ch_act[c]),
      .idx_o        (ch_idx[c]),
      .prio_o       (ch_prio[c])
    );
  end

  assign irq_o = ch_act[CH_NRM];
  assign fiq_o = ch_act[CH_FST];

  // read path
  always_comb begin
    bus_rdata_o = '0;
    if (line_hit) begin
      bus_rdata_o[0]          = steer_q[line_n];
      bus_rdata_o[PRIO_W+1:2] = prio_q[line_n];
    end else begin
      case (bus_addr_i)
        ADDR_W'(REG_STAT): bus_rdata_o[0] = ~srst_q;
        ADDR_W'(REG_NWIN): bus_rdata_o = DATA_W'(ch_idx[CH_NRM]);
        ADDR_W'(REG_FWIN): bus_rdata_o = DATA_W'(ch_idx[CH_FST]);
        ADDR_W'(REG_NPRI): bus_rdata_o = DATA_W'(ch_prio[CH_NRM]);
        ADDR_W'(REG_FPRI): bus_rdata_o = DATA_W'(ch_prio[CH_FST]);
        ADDR_W'(REG_THR):  bus_rdata_o = DATA_W'(thr_q);
        default: begin
          for (int b = 0; b < NUM_BANK; b++) begin
            if (grp_sel == (ADDR_W-3)'(GRP0 + b)) begin
              case (grp_kind)
                GRP_RAW:  bus_rdata_o = DATA_W'(g_raw[b]);
                GRP_MASK: bus_rdata_o = DATA_W'(g_mask[b]);
                GRP_SSET: bus_rdata_o = DATA_W'(g_swi[b]);
                GRP_PNRM: bus_rdata_o = DATA_W'(g_pnrm[b]);
                GRP_PFST: bus_rdata_o = DATA_W'(g_pfst[b]);
                default:  bus_rdata_o = '0;
              endcase
            end
          end
        end
      endcase
    end
  end

  // R11
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    srst_q |=> (!irq_o && !fiq_o));
  // R9
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (ch_found[CH_NRM] && !thr_off) |-> (THR_W'(ch_cprio[CH_NRM]) < thr_q));
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [95:0] src;
  logic        irq, fiq;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_intc u_vec_intc (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src),
    .irq_o(irq), .fiq_o(fiq)
  );

  localparam logic [7:0] A_CFG = 8'h00, A_STAT = 8'h01, A_NWIN = 8'h02, A_FWIN = 8'h03,
                         A_ACK = 8'h04, A_NPRI = 8'h05, A_FPRI = 8'h06, A_THR = 8'h07;

  // {line a, prio a, line b, prio b, expected winner}
  localparam logic [32:0] TBL [6] = '{
    {7'd5,  6'd3,  7'd70, 6'd1,  7'd70},
    {7'd10, 6'd2,  7'd4,  6'd2,  7'd4},
    {7'd95, 6'd0,  7'd0,  6'd5,  7'd95},
    {7'd33, 6'd7,  7'd64, 6'd7,  7'd33},
    {7'd31, 6'd0,  7'd32, 6'd0,  7'd31},
    {7'd63, 6'd63, 7'd62, 6'd63, 7'd62}
  };

  function automatic logic [7:0] ga(int grp, int k);
    return 8'(8'h10 + grp * 8 + k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #2;
    d = rdata;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic quiet_all();
    src = '0;
    for (int g = 0; g < 3; g++) begin
      wr_reg(ga(g, 2), 32'hFFFF_FFFF);
      wr_reg(ga(g, 5), 32'hFFFF_FFFF);
    end
    wr_reg(A_ACK, 32'h3);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    for (int g = 0; g < 3; g++) begin
      rd_reg(ga(g, 1), v); chk("R1 mask", v, 32'hFFFF_FFFF);
    end
    rd_reg(A_THR, v);   chk("R1 thr", v, 32'hFF);
    rd_reg(8'h80 + 8'd50, v); chk("R1 line", v, 0);
    rd_reg(A_STAT, v);  chk("R1 status", v, 1);

    // table: arbitration between two lines (R6, R10, thr 0xFF R9)
    for (int t = 0; t < 6; t++) begin
      automatic int a  = int'(TBL[t][32:26]);
      automatic int pa = int'(TBL[t][25:20]);
      automatic int b  = int'(TBL[t][19:13]);
      automatic int pb = int'(TBL[t][12:7]);
      automatic int ex = int'(TBL[t][6:0]);
      automatic int ep = (ex == a) ? pa : pb;
      wr_reg(8'(8'h80 + a), 32'(pa << 2));
      wr_reg(8'(8'h80 + b), 32'(pb << 2));
      wr_reg(ga(a / 32, 3), 32'(1) << (a % 32));
      wr_reg(ga(b / 32, 3), 32'(1) << (b % 32));
      @(negedge clk);
      src[a] = 1'b1; src[b] = 1'b1;
      @(negedge clk);
      chk("R6 table irq", 32'(irq), 1);
      rd_reg(A_NWIN, v); chk("R6 table winner", v, 32'(ex));
      rd_reg(A_NPRI, v); chk("R10 table prio", v, 32'(ep));
      src[a] = 1'b0; src[b] = 1'b0;
      wr_reg(A_ACK, 32'h1);
      wr_reg(8'(8'h80 + a), 0);
      wr_reg(8'(8'h80 + b), 0);
      quiet_all();
      chk("R8 table idle", 32'(irq), 0);
    end

    // R12 raw visible while masked; line 40 is group 1 bit 8
    @(negedge clk); src[40] = 1'b1;
    rd_reg(ga(1, 0), v); chk("R12 raw", v, 32'h100);
    @(negedge clk);
    chk("R12 masked no irq", 32'(irq), 0);
    rd_reg(ga(1, 6), v); chk("R3 masked not pending", v, 0);

    // R2 mask aliases
    wr_reg(ga(1, 3), 32'h0000_0F00);
    rd_reg(ga(1, 1), v); chk("R2 clear alias", v, 32'hFFFF_F0FF);
    wr_reg(ga(1, 2), 32'h0000_0300);
    rd_reg(ga(1, 1), v); chk("R2 set alias", v, 32'hFFFF_F3FF);
    rd_reg(ga(1, 6), v); chk("R3 remasked", v, 0);
    wr_reg(ga(1, 3), 32'h0000_0100);
    rd_reg(ga(1, 1), v); chk("R2 zeros untouched", v, 32'hFFFF_F2FF);
    rd_reg(ga(1, 6), v); chk("R3 pending normal", v, 32'h100);
    rd_reg(A_NWIN, v);   chk("R6 single winner", v, 40);

    // R8 acknowledge and fresh selection
    wr_reg(A_ACK, 32'h1);
    chk("R8 irq dropped", 32'(irq), 0);
    @(negedge clk);
    chk("R8 reselected", 32'(irq), 1);

    // R5 steering to the fast output
    wr_reg(8'h80 + 8'd40, 32'h17);
    rd_reg(8'h80 + 8'd40, v); chk("R5 line readback", v, 32'h15);
    rd_reg(ga(1, 6), v); chk("R3 pend normal after steer", v, 0);
    rd_reg(ga(1, 7), v); chk("R3 pend fast", v, 32'h100);
    chk("R5 fiq raised", 32'(fiq), 1);
    rd_reg(A_FWIN, v); chk("R6 fast winner", v, 40);
    rd_reg(A_FPRI, v); chk("R10 fast prio", v, 5);
    wr_reg(A_ACK, 32'h1);
    @(negedge clk);
    chk("R8 irq stays low", 32'(irq), 0);
    chk("R8 fiq untouched by bit0", 32'(fiq), 1);
    wr_reg(A_ACK, 32'h2);
    chk("R8 fiq dropped", 32'(fiq), 0);
    @(negedge clk);
    chk("R8 fiq reselected", 32'(fiq), 1);
    src[40] = 1'b0;
    wr_reg(8'h80 + 8'd40, 0);
    quiet_all();
    chk("R8 fiq idle", 32'(fiq), 0);

    // R7 hold against drop and more urgent arrival
    wr_reg(8'h80 + 8'd20, 32'h28);
    wr_reg(8'h80 + 8'd3, 0);
    wr_reg(ga(0, 3), 32'h0010_0008);
    @(negedge clk); src[20] = 1'b1;
    rd_reg(A_NWIN, v); chk("R6 line20", v, 20);
    src[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(A_NWIN, v); chk("R7 held over urgent", v, 20);
    src[20] = 1'b0;
    rd_reg(A_NWIN, v); chk("R7 held after drop", v, 20);
    chk("R7 irq held", 32'(irq), 1);
    rd_reg(A_NPRI, v); chk("R10 held prio", v, 10);
    wr_reg(A_ACK, 32'h1);
    chk("R8 drop before reselect", 32'(irq), 0);
    rd_reg(A_NWIN, v); chk("R8 new winner", v, 3);
    wr_reg(8'h80 + 8'd20, 0);
    quiet_all();

    // R4 software requests on line 69 (group 2 bit 5)
    wr_reg(ga(2, 3), 32'h20);
    wr_reg(ga(2, 4), 32'h20);
    rd_reg(ga(2, 4), v); chk("R4 swi readback", v, 32'h20);
    chk("R4 swi raises irq", 32'(irq), 1);
    rd_reg(A_NWIN, v); chk("R4 swi winner", v, 69);
    wr_reg(ga(2, 5), 32'h20);
    rd_reg(ga(2, 4), v); chk("R4 swi cleared", v, 0);
    wr_reg(A_ACK, 32'h1);
    @(negedge clk);
    chk("R4 no request after clear", 32'(irq), 0);
    quiet_all();

    // R9 threshold
    wr_reg(8'h80 + 8'd7, 32'h10);
    wr_reg(8'h80 + 8'd8, 32'h14);
    wr_reg(ga(0, 3), 32'h180);
    wr_reg(A_THR, 32'h4);
    @(negedge clk); src[7] = 1'b1; src[8] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 all filtered", 32'(irq), 0);
    rd_reg(A_THR, v); chk("R9 thr readback", v, 4);
    wr_reg(A_THR, 32'h5);
    @(negedge clk);
    chk("R9 below thr delivered", 32'(irq), 1);
    rd_reg(A_NWIN, v); chk("R9 winner", v, 7);
    wr_reg(8'h80 + 8'd7, 0);
    wr_reg(8'h80 + 8'd8, 0);
    wr_reg(A_THR, 32'hFF);
    quiet_all();

    // R11 soft reset
    wr_reg(ga(0, 3), 32'h1);
    wr_reg(A_THR, 32'h10);
    wr_reg(8'h80 + 8'd5, 32'hFC);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk);
    chk("R11 setup irq", 32'(irq), 1);
    wr_reg(A_CFG, 32'h2);
    peek(A_STAT, v); chk("R11 status busy", v, 0);
    rd_reg(A_STAT, v); chk("R11 status done", v, 1);
    rd_reg(ga(0, 1), v); chk("R11 mask restored", v, 32'hFFFF_FFFF);
    rd_reg(A_THR, v); chk("R11 thr restored", v, 32'hFF);
    rd_reg(8'h80 + 8'd5, v); chk("R11 line restored", v, 0);
    chk("R11 irq low", 32'(irq), 0);
    src = '0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule